// File: doc/BRIEF.md
# Four-bit bit-slice ALU element

The block is one four-bit slice of a microprogrammed datapath. A sixteen-word register file is read at two addresses, A and B, in the same cycle. A separate Q register serves as an accumulator or shift extension. A nine-bit instruction drives the slice every cycle. Its low three bits choose the operand pair (R, S) from the A and B words, Q, the external D input and zero. Its middle three bits choose one of eight arithmetic or logic functions. Its top three bits choose where the result goes: Q, the register file at address B, both, or neither, with an optional one-place shift up or down.

Shifts are carried through separate boundary pins. The bit that enters the vacated position comes from an input pin, and the bit that falls off is driven on an output pin, so adjacent slices can be chained into wider words. The Y output shows the function result, or the A word for one destination code, and is forced to zero when the output enable is low. Flags report carry-out, signed overflow, sign, zero and the slice's group carry propagate and generate.

Top module: `bitslice_alu`

## Requirements
- R1: The register file is read combinationally at addr_a_i and addr_b_i, and is written at addr_b_i on the rising clock edge. A read of the word being written in the same cycle returns the value it held before that edge.
- R2: instr_i[2:0] selects (R,S): 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0).
- R3: instr_i[5:3] selects F: 0=R+S+cin, 1=S-R-1+cin, 2=R-S-1+cin, 3=R|S, 4=R&S, 5=~R&S, 6=R^S, 7=~(R^S).
- R4: For functions 0 to 2, let x and y be the adder inputs: x=R, y=S for function 0; x=~R, y=S for function 1; x=R, y=~S for function 2. Then cout_o is the carry out of bit 3, ovf_o is the carry into bit 3 XOR the carry out of bit 3, prop_o is the AND over all bits of (x|y), and gen_o is the carry out of bit 3 with the carry-in forced to 0. For functions 3 to 7, all four flags are 0.
- R5: zero_o is 1 exactly when F is 0, and sign_o equals F[3], whatever the destination code.
- R6: Destination code instr_i[8:6]=0 loads F into Q. Code 1 writes nothing. Neither code writes the register file, and for both Y=F.
- R7: Code 2 writes F to the register file and drives Y with the A word. Code 3 writes F to the register file with Y=F.
- R8: Code 4 writes {ram_sh_msb_i, F[3:1]} to the register file and {q_sh_msb_i, Q[3:1]} to Q. It drives F[0] on ram_sh_lsb_o and Q[0] on q_sh_lsb_o.
- R9: Code 5 writes {ram_sh_msb_i, F[3:1]} to the register file, drives F[0] on ram_sh_lsb_o and leaves Q unchanged.
- R10: Code 6 writes {F[2:0], ram_sh_lsb_i} to the register file and {Q[2:0], q_sh_lsb_i} to Q. It drives F[3] on ram_sh_msb_o and Q[3] on q_sh_msb_o.
- R11: Code 7 writes {F[2:0], ram_sh_lsb_i} to the register file, drives F[3] on ram_sh_msb_o and leaves Q unchanged. For every code, a shift output pin whose shifter is not shifting in that direction is 0.
- R12: With oe_i low, y_o is 0 and the flags are unaffected.
- R13: While rst_ni is low, all register-file words and Q are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 9 | Destination [8:6], function [5:3], source [2:0] |
| addr_a_i | input | 4 | Register file read address A |
| addr_b_i | input | 4 | Register file read and write address B |
| d_i | input | 4 | External data operand |
| cin_i | input | 1 | Carry into bit 0 |
| oe_i | input | 1 | Output enable for y_o |
| ram_sh_lsb_i | input | 1 | Bit entering register-file bit 0 on an up shift |
| ram_sh_msb_i | input | 1 | Bit entering register-file bit 3 on a down shift |
| q_sh_lsb_i | input | 1 | Bit entering Q bit 0 on an up shift |
| q_sh_msb_i | input | 1 | Bit entering Q bit 3 on a down shift |
| y_o | output | 4 | F, or the A word for destination 2; 0 when disabled |
| ram_sh_lsb_o | output | 1 | F[0] on a register-file down shift, else 0 |
| ram_sh_msb_o | output | 1 | F[3] on a register-file up shift, else 0 |
| q_sh_lsb_o | output | 1 | Q[0] on a Q down shift, else 0 |
| q_sh_msb_o | output | 1 | Q[3] on a Q up shift, else 0 |
| cout_o | output | 1 | Carry out of bit 3 |
| ovf_o | output | 1 | Signed overflow |
| sign_o | output | 1 | F[3] |
| zero_o | output | 1 | F equals zero |
| prop_o | output | 1 | Group carry propagate |
| gen_o | output | 1 | Group carry generate |

## Verification
The hardest case to observe is a write that must not happen. For example, a destination 0 or 1 cycle must leave the B word untouched, and a destination 5 or 7 cycle must leave Q untouched. Neither word appears at a port until a later instruction routes it to Y through the source field. The stimulus therefore follows each destination exercise with reads of B and Q through the (0,B) and (0,Q) sources, and checks them against a model of all sixteen words and Q. The same-cycle read and write of one B word is set up on purpose, so that the value before the edge and the value after it are both seen on Y.

// File: rtl/bitslice_pkg.sv
package bitslice_pkg;

  typedef enum logic [2:0] {
    SRC_AQ, SRC_AB, SRC_ZQ, SRC_ZB, SRC_ZA, SRC_DA, SRC_DQ, SRC_DZ
  } src_e;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUBR, FN_SUBS, FN_OR, FN_AND, FN_NOTRS, FN_XOR, FN_XNOR
  } func_e;

  typedef enum logic [2:0] {
    DST_QREG, DST_NOP, DST_RAMA, DST_RAMF, DST_RAMQD, DST_RAMD, DST_RAMQU, DST_RAMU
  } dst_e;

  typedef enum logic [1:0] {
    SH_NONE, SH_DOWN, SH_UP
  } sh_e;

  typedef struct packed {
    logic rf_we;
    logic q_we;
    logic q_load_f;
    logic y_sel_a;
    sh_e  rf_sh;
    sh_e  q_sh;
  } dst_ctrl_t;

endpackage

// File: rtl/bitslice_regfile.sv
module bitslice_regfile #(
  parameter int unsigned W     = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);

  logic [W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '0;
      end else if (we_i && (waddr_i == AW'(g))) begin
        word_q <= wdata_i;
      end
    end
    assign words[g] = word_q;
  end

  assign rdata_a_o = words[raddr_a_i];
  assign rdata_b_o = words[raddr_b_i];

endmodule

// File: rtl/bitslice_alu_core.sv
module bitslice_alu_core
  import bitslice_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] s_i,
  input  func_e        fn_i,
  input  logic         cin_i,
  output logic [W-1:0] f_o,
  output logic         cout_o,
  output logic         ovf_o,
  output logic         prop_o,
  output logic         gen_o
);

  logic         arith;
  logic [W-1:0] x, y, sum;
  logic [W:0]   c, gg;

  always_comb begin
    arith = 1'b1;
    x     = r_i;
    y     = s_i;
    unique case (fn_i)
      FN_SUBR: x = ~r_i;
      FN_SUBS: y = ~s_i;
      FN_ADD:  ;
      default: arith = 1'b0;
    endcase
  end

  assign c[0]  = cin_i;
  assign gg[0] = 1'b0;

  // ripple chain; gg is the same chain with carry-in tied low
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign sum[g]  = x[g] ^ y[g] ^ c[g];
    assign c[g+1]  = (x[g] & y[g]) | ((x[g] ^ y[g]) & c[g]);
    assign gg[g+1] = (x[g] & y[g]) | ((x[g] | y[g]) & gg[g]);
  end

  always_comb begin
    unique case (fn_i)
      FN_OR:    f_o = r_i | s_i;
      FN_AND:   f_o = r_i & s_i;
      FN_NOTRS: f_o = ~r_i & s_i;
      FN_XOR:   f_o = r_i ^ s_i;
      FN_XNOR:  f_o = ~(r_i ^ s_i);
      default:  f_o = sum;
    endcase
  end

  assign cout_o = arith & c[W];
  assign ovf_o  = arith & (c[W] ^ c[W-1]);
  assign prop_o = arith & (&(x | y));
  assign gen_o  = arith & gg[W];

endmodule

// File: rtl/bitslice_shift.sv
module bitslice_shift
  import bitslice_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  sh_e          mode_i,
  input  logic [W-1:0] din_i,
  input  logic         lsb_in_i,
  input  logic         msb_in_i,
  output logic [W-1:0] dout_o,
  output logic         lsb_out_o,
  output logic         msb_out_o
);

  always_comb begin
    unique case (mode_i)
      SH_DOWN: dout_o = {msb_in_i, din_i[W-1:1]};
      SH_UP:   dout_o = {din_i[W-2:0], lsb_in_i};
      default: dout_o = din_i;
    endcase
  end

  assign lsb_out_o = (mode_i == SH_DOWN) & din_i[0];
  assign msb_out_o = (mode_i == SH_UP) & din_i[W-1];

endmodule

// File: rtl/bitslice_dest.sv
module bitslice_dest
  import bitslice_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  dst_e         dst_i,
  input  logic [W-1:0] f_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] a_i,
  input  logic         ram_lsb_i,
  input  logic         ram_msb_i,
  input  logic         q_lsb_i,
  input  logic         q_msb_i,
  output logic         rf_we_o,
  output logic [W-1:0] rf_wdata_o,
  output logic         q_we_o,
  output logic [W-1:0] q_wdata_o,
  output logic [W-1:0] y_o,
  output logic         ram_lsb_o,
  output logic         ram_msb_o,
  output logic         q_lsb_o,
  output logic         q_msb_o
);

  dst_ctrl_t    ctl;
  logic [W-1:0] q_shifted;

  always_comb begin
    ctl = '{rf_we: 1'b0, q_we: 1'b0, q_load_f: 1'b0, y_sel_a: 1'b0,
            rf_sh: SH_NONE, q_sh: SH_NONE};
    unique case (dst_i)
      DST_QREG:  begin ctl.q_we = 1'b1; ctl.q_load_f = 1'b1; end
      DST_NOP:   ;
      DST_RAMA:  begin ctl.rf_we = 1'b1; ctl.y_sel_a = 1'b1; end
      DST_RAMF:  ctl.rf_we = 1'b1;
      DST_RAMQD: begin ctl.rf_we = 1'b1; ctl.q_we = 1'b1;
                       ctl.rf_sh = SH_DOWN; ctl.q_sh = SH_DOWN; end
      DST_RAMD:  begin ctl.rf_we = 1'b1; ctl.rf_sh = SH_DOWN; end
      DST_RAMQU: begin ctl.rf_we = 1'b1; ctl.q_we = 1'b1;
                       ctl.rf_sh = SH_UP; ctl.q_sh = SH_UP; end
      DST_RAMU:  begin ctl.rf_we = 1'b1; ctl.rf_sh = SH_UP; end
      default:   ;
    endcase
  end

  bitslice_shift #(.W(W)) u_rf_sh (
    .mode_i    (ctl.rf_sh),
    .din_i     (f_i),
    .lsb_in_i  (ram_lsb_i),
    .msb_in_i  (ram_msb_i),
    .dout_o    (rf_wdata_o),
    .lsb_out_o (ram_lsb_o),
    .msb_out_o (ram_msb_o)
  );

  bitslice_shift #(.W(W)) u_q_sh (
    .mode_i    (ctl.q_sh),
    .din_i     (q_i),
    .lsb_in_i  (q_lsb_i),
    .msb_in_i  (q_msb_i),
    .dout_o    (q_shifted),
    .lsb_out_o (q_lsb_o),
    .msb_out_o (q_msb_o)
  );

  assign rf_we_o   = ctl.rf_we;
  assign q_we_o    = ctl.q_we;
  assign q_wdata_o = ctl.q_load_f ? f_i : q_shifted;
  assign y_o       = ctl.y_sel_a ? a_i : f_i;

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import bitslice_pkg::*;
#(
  parameter int unsigned W     = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [8:0]    instr_i,
  input  logic [AW-1:0] addr_a_i,
  input  logic [AW-1:0] addr_b_i,
  input  logic [W-1:0]  d_i,
  input  logic          cin_i,
  input  logic          oe_i,
  input  logic          ram_sh_lsb_i,
  input  logic          ram_sh_msb_i,
  input  logic          q_sh_lsb_i,
  input  logic          q_sh_msb_i,
  output logic [W-1:0]  y_o,
  output logic          ram_sh_lsb_o,
  output logic          ram_sh_msb_o,
  output logic          q_sh_lsb_o,
  output logic          q_sh_msb_o,
  output logic          cout_o,
  output logic          ovf_o,
  output logic          sign_o,
  output logic          zero_o,
  output logic          prop_o,
  output logic          gen_o
);

  src_e         src;
  func_e        fn;
  dst_e         dst;
  logic [W-1:0] rd_a, rd_b, q_q, r_op, s_op, f;
  logic [W-1:0] rf_wdata, q_wdata, y_int;
  logic         rf_we, q_we;

  assign src = src_e'(instr_i[2:0]);
  assign fn  = func_e'(instr_i[5:3]);
  assign dst = dst_e'(instr_i[8:6]);

  bitslice_regfile #(.W(W), .DEPTH(DEPTH)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (addr_b_i),
    .wdata_i   (rf_wdata),
    .raddr_a_i (addr_a_i),
    .raddr_b_i (addr_b_i),
    .rdata_a_o (rd_a),
    .rdata_b_o (rd_b)
  );

  always_comb begin
    unique case (src)
      SRC_AQ:  begin r_op = rd_a; s_op = q_q;  end
      SRC_AB:  begin r_op = rd_a; s_op = rd_b; end
      SRC_ZQ:  begin r_op = '0;   s_op = q_q;  end
      SRC_ZB:  begin r_op = '0;   s_op = rd_b; end
      SRC_ZA:  begin r_op = '0;   s_op = rd_a; end
      SRC_DA:  begin r_op = d_i;  s_op = rd_a; end
      SRC_DQ:  begin r_op = d_i;  s_op = q_q;  end
      default: begin r_op = d_i;  s_op = '0;   end
    endcase
  end

  bitslice_alu_core #(.W(W)) u_alu (
    .r_i    (r_op),
    .s_i    (s_op),
    .fn_i   (fn),
    .cin_i  (cin_i),
    .f_o    (f),
    .cout_o (cout_o),
    .ovf_o  (ovf_o),
    .prop_o (prop_o),
    .gen_o  (gen_o)
  );

  bitslice_dest #(.W(W)) u_dest (
    .dst_i      (dst),
    .f_i        (f),
    .q_i        (q_q),
    .a_i        (rd_a),
    .ram_lsb_i  (ram_sh_lsb_i),
    .ram_msb_i  (ram_sh_msb_i),
    .q_lsb_i    (q_sh_lsb_i),
    .q_msb_i    (q_sh_msb_i),
    .rf_we_o    (rf_we),
    .rf_wdata_o (rf_wdata),
    .q_we_o     (q_we),
    .q_wdata_o  (q_wdata),
    .y_o        (y_int),
    .ram_lsb_o  (ram_sh_lsb_o),
    .ram_msb_o  (ram_sh_msb_o),
    .q_lsb_o    (q_sh_lsb_o),
    .q_msb_o    (q_sh_msb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (q_we) q_q <= q_wdata;
  end

  assign y_o    = oe_i ? y_int : '0;
  assign sign_o = f[W-1];
  assign zero_o = (f == '0);

endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [8:0]   instr_i,
  input logic         oe_i,
  input logic [W-1:0] y_o,
  input logic         cout_o,
  input logic         ovf_o,
  input logic         zero_o,
  input logic         q_sh_lsb_i,
  input logic         q_sh_msb_i,
  input logic [W-1:0] q_q,
  input logic         rf_we
);

  logic [2:0] dst;
  assign dst = instr_i[8:6];

  a_r6_no_rf_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst == 3'd0 || dst == 3'd1) |-> !rf_we);

  a_r9_q_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst inside {3'd1, 3'd2, 3'd3, 3'd5, 3'd7}) |=> (q_q == $past(q_q)));

  a_r8_q_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst == 3'd4) |=> (q_q == {$past(q_sh_msb_i), $past(q_q[W-1:1])}));

  a_r10_q_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst == 3'd6) |=> (q_q == {$past(q_q[W-2:0]), $past(q_sh_lsb_i)}));

  a_r12_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (y_o == '0));

  a_r4_logic_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[5:3] >= 3'd3) |-> (!cout_o && !ovf_o));

  a_r5_zero_y: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && dst != 3'd2 && zero_o) |-> (y_o == '0));

endmodule

bind bitslice_alu bitslice_alu_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .instr_i    (instr_i),
  .oe_i       (oe_i),
  .y_o        (y_o),
  .cout_o     (cout_o),
  .ovf_o      (ovf_o),
  .zero_o     (zero_o),
  .q_sh_lsb_i (q_sh_lsb_i),
  .q_sh_msb_i (q_sh_msb_i),
  .q_q        (q_q),
  .rf_we      (rf_we)
);

// File: tb/bitslice_alu_tb.sv
module bitslice_alu_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] instr = '0;
  logic [3:0] addr_a = '0, addr_b = '0, d = '0;
  logic       cin = 1'b0, oe = 1'b1;
  logic       rl_i = 1'b0, rm_i = 1'b0, ql_i = 1'b0, qm_i = 1'b0;
  logic [3:0] y;
  logic       rl_o, rm_o, ql_o, qm_o, cout, ovf, sign, zero, prop, gen;

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitslice_alu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .addr_a_i(addr_a),
    .addr_b_i(addr_b), .d_i(d), .cin_i(cin), .oe_i(oe),
    .ram_sh_lsb_i(rl_i), .ram_sh_msb_i(rm_i), .q_sh_lsb_i(ql_i), .q_sh_msb_i(qm_i),
    .y_o(y), .ram_sh_lsb_o(rl_o), .ram_sh_msb_o(rm_o), .q_sh_lsb_o(ql_o),
    .q_sh_msb_o(qm_o), .cout_o(cout), .ovf_o(ovf), .sign_o(sign), .zero_o(zero),
    .prop_o(prop), .gen_o(gen)
  );

  // model state and expectations
  logic [3:0] m_rf [16];
  logic [3:0] m_q;
  logic [3:0] e_y, n_rf_d, n_q;
  logic       n_rf_we;
  logic       e_cout, e_ovf, e_prop, e_gen, e_zero, e_sign;
  logic       e_rl, e_rm, e_ql, e_qm;

  // {instr, a, b, d, cin, {ram_lsb, ram_msb, q_lsb, q_msb}}
  localparam int NV = 26;
  localparam logic [25:0] VECS [NV] = '{
    {9'o337, 4'd0, 4'd0, 4'd3,  1'b0, 4'b0000},
    {9'o337, 4'd0, 4'd1, 4'd12, 1'b0, 4'b0000},
    {9'o337, 4'd0, 4'd2, 4'd5,  1'b0, 4'b0000},
    {9'o337, 4'd0, 4'd3, 4'd10, 1'b0, 4'b0000},
    {9'o337, 4'd0, 4'd4, 4'd15, 1'b0, 4'b0000},
    {9'o337, 4'd0, 4'd5, 4'd0,  1'b0, 4'b0000},
    {9'o337, 4'd0, 4'd6, 4'd7,  1'b0, 4'b0000},
    {9'o337, 4'd0, 4'd7, 4'd8,  1'b0, 4'b0000},
    {9'o000, 4'd1, 4'd0, 4'd0,  1'b0, 4'b0000},
    {9'o102, 4'd0, 4'd0, 4'd0,  1'b0, 4'b0000},
    {9'o205, 4'd2, 4'd9, 4'd1,  1'b0, 4'b0000},
    {9'o103, 4'd0, 4'd9, 4'd0,  1'b0, 4'b0000},
    {9'o432, 4'd0, 4'd10, 4'd0, 1'b0, 4'b0101},
    {9'o102, 4'd0, 4'd0, 4'd0,  1'b0, 4'b0000},
    {9'o103, 4'd0, 4'd10, 4'd0, 1'b0, 4'b0000},
    {9'o537, 4'd0, 4'd11, 4'd13, 1'b0, 4'b1111},
    {9'o102, 4'd0, 4'd0, 4'd0,  1'b0, 4'b0000},
    {9'o632, 4'd0, 4'd12, 4'd0, 1'b0, 4'b1010},
    {9'o102, 4'd0, 4'd0, 4'd0,  1'b0, 4'b0000},
    {9'o737, 4'd0, 4'd13, 4'd9, 1'b0, 4'b1111},
    {9'o102, 4'd0, 4'd0, 4'd0,  1'b0, 4'b0000},
    {9'o103, 4'd0, 4'd13, 4'd0, 1'b0, 4'b0000},
    {9'o011, 4'd4, 4'd2, 4'd0,  1'b1, 4'b0000},
    {9'o103, 4'd0, 4'd2, 4'd0,  1'b0, 4'b0000},
    {9'o421, 4'd6, 4'd4, 4'd0,  1'b0, 4'b0000},
    {9'o601, 4'd1, 4'd3, 4'd0,  1'b1, 4'b0011}
  };

  function automatic string dst_tag(input logic [2:0] dc);
    case (dc)
      3'd0, 3'd1: return "R6";
      3'd2, 3'd3: return "R7";
      3'd4:       return "R8";
      3'd5:       return "R9";
      3'd6:       return "R10";
      default:    return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_eval(input logic [8:0] ins, input logic [3:0] a, b, dv,
                            input logic ci, input logic [3:0] sh, input logic en);
    logic [3:0] r, s, x, yy, f;
    logic [4:0] sum5, lo, g5;
    logic arith;
    case (ins[2:0])
      3'd0: begin r = m_rf[a]; s = m_q;     end
      3'd1: begin r = m_rf[a]; s = m_rf[b]; end
      3'd2: begin r = 4'd0;    s = m_q;     end
      3'd3: begin r = 4'd0;    s = m_rf[b]; end
      3'd4: begin r = 4'd0;    s = m_rf[a]; end
      3'd5: begin r = dv;      s = m_rf[a]; end
      3'd6: begin r = dv;      s = m_q;     end
      default: begin r = dv;   s = 4'd0;    end
    endcase
    arith = (ins[5:3] <= 3'd2);
    x = (ins[5:3] == 3'd1) ? ~r : r;
    yy = (ins[5:3] == 3'd2) ? ~s : s;
    sum5 = {1'b0, x} + {1'b0, yy} + {4'd0, ci};
    lo = {2'b0, x[2:0]} + {2'b0, yy[2:0]} + {4'd0, ci};
    g5 = {1'b0, x} + {1'b0, yy};
    case (ins[5:3])
      3'd3: f = r | s;
      3'd4: f = r & s;
      3'd5: f = ~r & s;
      3'd6: f = r ^ s;
      3'd7: f = ~(r ^ s);
      default: f = sum5[3:0];
    endcase
    e_cout = arith & sum5[4];
    e_ovf  = arith & (sum5[4] ^ lo[3]);
    e_prop = arith & ((x | yy) == 4'hF);
    e_gen  = arith & g5[4];
    e_zero = (f == 4'd0);
    e_sign = f[3];
    e_y = (ins[8:6] == 3'd2) ? m_rf[a] : f;
    if (!en) e_y = 4'd0;
    n_rf_we = (ins[8:6] >= 3'd2);
    n_rf_d = f;
    n_q = m_q;
    e_rl = 0; e_rm = 0; e_ql = 0; e_qm = 0;
    case (ins[8:6])
      3'd0: n_q = f;
      3'd4: begin n_rf_d = {sh[2], f[3:1]}; e_rl = f[0];
                  n_q = {sh[0], m_q[3:1]}; e_ql = m_q[0]; end
      3'd5: begin n_rf_d = {sh[2], f[3:1]}; e_rl = f[0]; end
      3'd6: begin n_rf_d = {f[2:0], sh[3]}; e_rm = f[3];
                  n_q = {m_q[2:0], sh[1]}; e_qm = m_q[3]; end
      3'd7: begin n_rf_d = {f[2:0], sh[3]}; e_rm = f[3]; end
      default: ;
    endcase
  endtask

  task automatic step(input logic [8:0] ins, input logic [3:0] a, b, dv,
                      input logic ci, input logic [3:0] sh, input logic en,
                      input string ytag);
    string st;
    @(negedge clk);
    instr = ins; addr_a = a; addr_b = b; d = dv; cin = ci; oe = en;
    {rl_i, rm_i, ql_i, qm_i} = sh;
    #1;
    model_eval(ins, a, b, dv, ci, sh, en);
    st = dst_tag(ins[8:6]);
    chk(ytag, y, e_y);
    chk("R4", {cout, ovf, prop, gen}, {e_cout, e_ovf, e_prop, e_gen});
    chk("R5", {2'b0, zero, sign}, {2'b0, e_zero, e_sign});
    chk(st, {rl_o, rm_o, ql_o, qm_o}, {e_rl, e_rm, e_ql, e_qm});
    @(posedge clk);
    if (n_rf_we) m_rf[b] = n_rf_d;
    m_q = n_q;
  endtask

  task automatic clear_model();
    for (int i = 0; i < 16; i++) m_rf[i] = 4'd0;
    m_q = 4'd0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R13: reset state seen through reads of a word and Q
    step(9'o104, 4'd5, 4'd0, 4'd0, 1'b0, 4'b0, 1'b1, "R13");
    chk("R13", y, 4'd0);
    chk("R13", {3'b0, zero}, 4'd1);
    step(9'o102, 4'd0, 4'd0, 4'd0, 1'b0, 4'b0, 1'b1, "R13");
    chk("R13", y, 4'd0);

    // table walk: preloads and every destination code
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VECS[i];
      step(v[25:17], v[16:13], v[12:9], v[8:5], v[4], v[3:0], 1'b1,
           dst_tag(v[25:23]));
    end

    // R2 R3: every source and function with both carries, no write-back
    for (int sc = 0; sc < 8; sc++)
      for (int fc = 0; fc < 8; fc++)
        for (int ci = 0; ci < 2; ci++)
          step({3'd1, 3'(fc), 3'(sc)}, 4'(sc), 4'(7 - sc), 4'(3 * fc + ci + 5),
               1'(ci), 4'b0, 1'b1, (fc >= 6) ? "R3" : "R2");

    // R1: write then read, and same-cycle read of the word being written
    step(9'o337, 4'd0, 4'd3, 4'd9, 1'b0, 4'b0, 1'b1, "R1");
    step(9'o104, 4'd3, 4'd0, 4'd0, 1'b0, 4'b0, 1'b1, "R1");
    chk("R1", y, 4'd9);
    step(9'o303, 4'd0, 4'd3, 4'd0, 1'b1, 4'b0, 1'b1, "R1");
    chk("R1", y, 4'd10);
    step(9'o104, 4'd3, 4'd0, 4'd0, 1'b0, 4'b0, 1'b1, "R1");
    chk("R1", y, 4'd10);

    // R3: the two exclusive-or codes
    step(9'o167, 4'd0, 4'd0, 4'd6, 1'b0, 4'b0, 1'b1, "R3");
    chk("R3", y, 4'd6);
    step(9'o177, 4'd0, 4'd0, 4'd6, 1'b0, 4'b0, 1'b1, "R3");
    chk("R3", y, 4'd9);

    // R12: disabled output with a nonzero result
    step(9'o104, 4'd3, 4'd0, 4'd0, 1'b0, 4'b0, 1'b0, "R12");
    chk("R12", y, 4'd0);
    chk("R12", {3'b0, zero}, 4'd0);

    // R13: reset in mid-run clears written words
    @(negedge clk) rst_n = 1'b0;
    clear_model();
    @(negedge clk) rst_n = 1'b1;
    step(9'o104, 4'd3, 4'd0, 4'd0, 1'b0, 4'b0, 1'b1, "R13");
    chk("R13", y, 4'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule